// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block drives a bus-master data path from a chain of 16-byte transfer descriptors held in memory. A start pulse hands it the address of the first descriptor. It reads each descriptor whole through a request/response memory port and decodes the buffer address, the length (counted in 8-byte units) and the per-entry control bits. It then offers one transfer command (address, byte count, direction, ordering, mode) on a valid/ready port. When the data path accepts the command, the walker either follows the entry's next pointer or, if the entry is flagged as last, pulses `done` and goes idle.

A descriptor is rejected before any transfer is issued if it carries a buffer address off an 8-byte boundary, a zero length, or (on a non-last entry) an unaligned next pointer. A start pointer off an 8-byte boundary is also rejected. In each of these cases the walker pulses `err` and returns to idle. An `abort` input returns it to idle at the next clock edge, whatever it was doing. The data mover and its FIFO sit outside this block.

Top module: `prd_chain_walker`

## Requirements
- R1: After reset `busy`, `rd_req_valid`, `xfer_valid`, `done` and `err` are all 0.
- R2: A `start` pulse in idle with an aligned pointer raises `rd_req_valid` with `rd_req_addr` equal to that pointer in the next cycle. The request and its address hold until `rd_req_ready`.
- R3: The response word carries byte k at bits 8k+7..8k. Bytes 0..3 (little-endian) become `xfer_addr`. Bytes 4..7 are the length in 8-byte units, and `xfer_bytes` equals that length times 8.
- R4: In byte 8, bit 4 drives `xfer_ordered` and bit 5 drives `xfer_dir_out` (1 = host to device). The low 4 bits of byte 9 drive `xfer_mode`. Bytes 10 and 11 have no effect.
- R5: After an entry without the last flag is accepted, the next descriptor is fetched from the address held in bytes 12..15.
- R6: An entry whose byte 8 bit 7 is set ends the chain. `done` pulses for one cycle in the cycle after its transfer is accepted, and its next-pointer field is ignored even when misaligned.
- R7: A descriptor whose buffer address, or (if not last) next pointer, has any of bits 2..0 set issues no transfer. `err` pulses and the walker goes idle.
- R8: A descriptor whose length is 0 issues no transfer. `err` pulses and the walker goes idle.
- R9: A `start` with a pointer whose bits 2..0 are not zero issues no memory read. `err` pulses in the next cycle.
- R10: `abort` forces `busy`, `rd_req_valid` and `xfer_valid` low in the next cycle. The aborted chain never produces `done`.
- R11: While `xfer_valid` is high and `xfer_ready` is low, the command fields stay stable.
- R12: A `start` while `busy` is high has no effect on the chain in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a chain at `start_ptr` |
| start_ptr | input | 32 | Address of the first descriptor |
| abort | input | 1 | Return to idle at once |
| rd_req_valid | output | 1 | Descriptor read request |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_req_addr | output | 32 | Descriptor address |
| rd_rsp_valid | input | 1 | Descriptor data present |
| rd_rsp_data | input | 128 | Whole descriptor, byte k at bits 8k+7..8k |
| xfer_valid | output | 1 | Transfer command valid |
| xfer_ready | input | 1 | Data path accepts the command |
| xfer_addr | output | 32 | Buffer address |
| xfer_bytes | output | LEN_W+3 | Byte count |
| xfer_dir_out | output | 1 | 1 = host to device |
| xfer_ordered | output | 1 | Ordering bit of the entry |
| xfer_mode | output | 4 | DMA mode of the entry |
| busy | output | 1 | A chain is in progress |
| done | output | 1 | One-cycle pulse at chain end |
| err | output | 1 | One-cycle pulse on a rejected descriptor or pointer |

## Verification
The bench builds the walker with its default LEN_W of 32. This makes the full 32-bit length field reachable, so an all-ones length must come out as the 35-bit count 0x7_FFFF_FFF8. The memory model accepts requests on two of every three cycles and answers two cycles later. The data-path model refuses one cycle in four and can stall indefinitely, which holds the walker in its issue state so that abort, command stability and starts while busy can all be exercised.

// File: rtl/prd_walk_pkg.sv
package prd_walk_pkg;

    localparam int unsigned PTR_W      = 32;
    localparam int unsigned ENTRY_W    = 128;
    localparam int unsigned ALIGN_LOG2 = 3;
    localparam int unsigned MODE_W     = 4;
    localparam int unsigned FLAG_ORD   = 4;
    localparam int unsigned FLAG_OUT   = 5;
    localparam int unsigned FLAG_LAST  = 7;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_FETCH = 2'd1,
        W_WAIT  = 2'd2,
        W_ISSUE = 2'd3
    } walk_state_e;

    typedef struct packed {
        logic [PTR_W-1:0]  addr;
        logic              ordered;
        logic              dir_out;
        logic [MODE_W-1:0] mode;
    } xfer_cmd_t;

    typedef struct packed {
        logic [PTR_W-1:0]  buf_addr;
        logic [31:0]       len_units;
        logic [7:0]        flags;
        logic [MODE_W-1:0] mode;
        logic [PTR_W-1:0]  next_ptr;
    } prd_fields_t;

    function automatic logic ptr_aligned(input logic [PTR_W-1:0] p);
        return p[ALIGN_LOG2-1:0] == '0;
    endfunction

    function automatic prd_fields_t split_entry(input logic [ENTRY_W-1:0] raw);
        prd_fields_t f;
        f.buf_addr  = raw[31:0];
        f.len_units = raw[63:32];
        f.flags     = raw[71:64];
        f.mode      = raw[64+8+MODE_W-1:72];
        f.next_ptr  = raw[127:96];
        return f;
    endfunction

endpackage

// File: rtl/prd_entry_decode.sv
module prd_entry_decode
    import prd_walk_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic [ENTRY_W-1:0] raw,
    output xfer_cmd_t          cmd,
    output logic [LEN_W+2:0]   byte_cnt,
    output logic               is_last,
    output logic [PTR_W-1:0]   next_ptr,
    output logic               fault
);
    prd_fields_t      f;
    logic [LEN_W-1:0] len_used;
    logic             unused_fields;

    always_comb begin
        f            = split_entry(raw);
        len_used     = f.len_units[LEN_W-1:0];
        cmd.addr     = f.buf_addr;
        cmd.ordered  = f.flags[FLAG_ORD];
        cmd.dir_out  = f.flags[FLAG_OUT];
        cmd.mode     = f.mode;
        byte_cnt     = {len_used, {ALIGN_LOG2{1'b0}}};
        is_last      = f.flags[FLAG_LAST];
        next_ptr     = f.next_ptr;
        fault        = !ptr_aligned(f.buf_addr)
                     || (len_used == '0)
                     || (!is_last && !ptr_aligned(f.next_ptr));
    end

    assign unused_fields = ^{raw[95:76], raw[63:32], raw[71:64]};

endmodule

// File: rtl/prd_walk_fsm.sv
module prd_walk_fsm
    import prd_walk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PTR_W-1:0] start_ptr,
    input  logic             abort,
    input  logic             req_ready,
    input  logic             rsp_valid,
    input  logic             xfer_ready,
    input  logic             ent_fault,
    input  logic             ent_last,
    input  logic [PTR_W-1:0] ent_next,
    output walk_state_e      state,
    output logic [PTR_W-1:0] ptr,
    output logic             load,
    output logic             done_pulse,
    output logic             err_pulse
);
    logic             last_q;
    logic [PTR_W-1:0] next_q;

    assign load = (state == W_WAIT) && rsp_valid && !abort && !ent_fault;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= W_IDLE;
            ptr        <= '0;
            last_q     <= 1'b0;
            next_q     <= '0;
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
        end else begin
            done_pulse <= 1'b0;
            err_pulse  <= 1'b0;
            if (abort) begin
                state <= W_IDLE;
            end else begin
                unique case (state)
                    W_IDLE: begin
                        if (start) begin
                            if (ptr_aligned(start_ptr)) begin
                                ptr   <= start_ptr;
                                state <= W_FETCH;
                            end else begin
                                err_pulse <= 1'b1;
                            end
                        end
                    end
                    W_FETCH: begin
                        if (req_ready) state <= W_WAIT;
                    end
                    W_WAIT: begin
                        if (rsp_valid) begin
                            if (ent_fault) begin
                                err_pulse <= 1'b1;
                                state     <= W_IDLE;
                            end else begin
                                last_q <= ent_last;
                                next_q <= ent_next;
                                state  <= W_ISSUE;
                            end
                        end
                    end
                    W_ISSUE: begin
                        if (xfer_ready) begin
                            if (last_q) begin
                                done_pulse <= 1'b1;
                                state      <= W_IDLE;
                            end else begin
                                ptr   <= next_q;
                                state <= W_FETCH;
                            end
                        end
                    end
                    default: state <= W_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/prd_chain_walker.sv
module prd_chain_walker
    import prd_walk_pkg::*;
#(
    parameter int unsigned LEN_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [31:0]        start_ptr,
    input  logic               abort,
    output logic               rd_req_valid,
    input  logic               rd_req_ready,
    output logic [31:0]        rd_req_addr,
    input  logic               rd_rsp_valid,
    input  logic [127:0]       rd_rsp_data,
    output logic               xfer_valid,
    input  logic               xfer_ready,
    output logic [31:0]        xfer_addr,
    output logic [LEN_W+2:0]   xfer_bytes,
    output logic               xfer_dir_out,
    output logic               xfer_ordered,
    output logic [3:0]         xfer_mode,
    output logic               busy,
    output logic               done,
    output logic               err
);
    xfer_cmd_t        dec_cmd;
    xfer_cmd_t        cmd_q;
    logic [LEN_W+2:0] dec_bytes;
    logic [LEN_W+2:0] bytes_q;
    logic             dec_last;
    logic [PTR_W-1:0] dec_next;
    logic             dec_fault;
    walk_state_e      state;
    logic [PTR_W-1:0] ptr;
    logic             load;

    prd_entry_decode #(.LEN_W(LEN_W)) dec_i (
        .raw      (rd_rsp_data),
        .cmd      (dec_cmd),
        .byte_cnt (dec_bytes),
        .is_last  (dec_last),
        .next_ptr (dec_next),
        .fault    (dec_fault)
    );

    prd_walk_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_ptr  (start_ptr),
        .abort      (abort),
        .req_ready  (rd_req_ready),
        .rsp_valid  (rd_rsp_valid),
        .xfer_ready (xfer_ready),
        .ent_fault  (dec_fault),
        .ent_last   (dec_last),
        .ent_next   (dec_next),
        .state      (state),
        .ptr        (ptr),
        .load       (load),
        .done_pulse (done),
        .err_pulse  (err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            bytes_q <= '0;
        end else if (load) begin
            cmd_q   <= dec_cmd;
            bytes_q <= dec_bytes;
        end
    end

    assign rd_req_valid = (state == W_FETCH);
    assign rd_req_addr  = ptr;
    assign xfer_valid   = (state == W_ISSUE);
    assign xfer_addr    = cmd_q.addr;
    assign xfer_bytes   = bytes_q;
    assign xfer_dir_out = cmd_q.dir_out;
    assign xfer_ordered = cmd_q.ordered;
    assign xfer_mode    = cmd_q.mode;
    assign busy         = (state != W_IDLE);

endmodule

// File: rtl/prd_chain_walker_chk.sv
module prd_chain_walker_chk #(
    parameter int unsigned LEN_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             abort,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [31:0]      rd_req_addr,
    input logic             xfer_valid,
    input logic             xfer_ready,
    input logic [31:0]      xfer_addr,
    input logic [LEN_W+2:0] xfer_bytes,
    input logic             xfer_dir_out,
    input logic             xfer_ordered,
    input logic [3:0]       xfer_mode,
    input logic             busy,
    input logic             done,
    input logic             err
);
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req_valid && !rd_req_ready && !abort) |=> (rd_req_valid && $stable(rd_req_addr)));

    a_r11_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (xfer_valid && !xfer_ready && !abort) |=>
        (xfer_valid && $stable(xfer_addr) && $stable(xfer_bytes) && $stable(xfer_dir_out)
         && $stable(xfer_ordered) && $stable(xfer_mode)));

    a_r10_abort_idle: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !rd_req_valid && !xfer_valid && !done));

    a_r6_done_after_accept: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(xfer_valid && xfer_ready && !abort));

    a_r9_req_aligned: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid |-> (rd_req_addr[2:0] == 3'b000));

    a_r7_cmd_aligned: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_addr[2:0] == 3'b000));

    a_r8_cmd_nonzero: assert property (@(posedge clk) disable iff (rst)
        xfer_valid |-> (xfer_bytes != '0));

    a_r7_single_outcome: assert property (@(posedge clk) disable iff (rst)
        !(done && err));

endmodule

bind prd_chain_walker prd_chain_walker_chk #(.LEN_W(LEN_W)) chk_i (.*);

// File: tb/prd_chain_walker_tb_top.sv
module prd_chain_walker_tb_top;
    localparam int unsigned LEN_W = 32;

    typedef struct {
        logic [31:0]      addr;
        logic [LEN_W+2:0] bytes;
        logic             dir_out;
        logic             ordered;
        logic [3:0]       mode;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [31:0] start_ptr = '0;
    logic abort = 1'b0;
    logic rd_req_valid;
    logic rd_req_ready = 1'b0;
    logic [31:0] rd_req_addr;
    logic rd_rsp_valid = 1'b0;
    logic [127:0] rd_rsp_data = '0;
    logic xfer_valid;
    logic xfer_ready = 1'b0;
    logic [31:0] xfer_addr;
    logic [LEN_W+2:0] xfer_bytes;
    logic xfer_dir_out;
    logic xfer_ordered;
    logic [3:0] xfer_mode;
    logic busy, done, err;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic sink_hold = 1'b0;
    exp_t exp_q[$];
    logic [127:0] mem [logic [31:0]];
    logic pend = 1'b0;
    int pend_cnt = 0;
    logic [31:0] pend_addr = '0;

    always #4 clk = ~clk;

    prd_chain_walker #(.LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_ptr(start_ptr), .abort(abort),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .xfer_addr(xfer_addr),
        .xfer_bytes(xfer_bytes), .xfer_dir_out(xfer_dir_out), .xfer_ordered(xfer_ordered),
        .xfer_mode(xfer_mode), .busy(busy), .done(done), .err(err)
    );

    function automatic void check(input bit ok, input string req, input string msg,
                                  input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, msg, act, exp);
        end
    endfunction

    // memory model, data-path sink and scoreboard monitor
    always @(negedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
        rd_rsp_valid = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : '0;
                pend = 1'b0;
            end else begin
                pend_cnt--;
            end
        end
        rd_req_ready = (cyc % 3) != 1;
        if (rd_req_valid && rd_req_ready && !rst) begin
            pend = 1'b1;
            pend_cnt = 1;
            pend_addr = rd_req_addr;
        end
        xfer_ready = !sink_hold && ((cyc % 4) != 2);
        if (xfer_valid && xfer_ready && !rst && !abort) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R5", "unexpected transfer addr", {32'd0, xfer_addr}, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(xfer_addr == e.addr, "R3", "addr", {32'd0, xfer_addr}, {32'd0, e.addr});
                check(xfer_bytes == e.bytes, "R3", "bytes", 64'(xfer_bytes), 64'(e.bytes));
                check({xfer_dir_out, xfer_ordered, xfer_mode} == {e.dir_out, e.ordered, e.mode},
                      "R4", "dir/ord/mode", {58'd0, xfer_dir_out, xfer_ordered, xfer_mode},
                      {58'd0, e.dir_out, e.ordered, e.mode});
            end
        end
    end

    task automatic put(input logic [31:0] at, input logic [31:0] buf_a, input logic [31:0] len,
                       input logic [7:0] flags, input logic [7:0] b9, input logic [31:0] nxt,
                       input bit expect_it);
        exp_t e;
        // byte 10 and 11 filled with junk: must have no effect (R4)
        mem[at] = {nxt, 8'hA5, 8'h5A, b9, flags, len, buf_a};
        if (expect_it) begin
            e.addr = buf_a;
            e.bytes = {len[LEN_W-1:0], 3'b000};
            e.dir_out = flags[5];
            e.ordered = flags[4];
            e.mode = b9[3:0];
            exp_q.push_back(e);
        end
    endtask

    task automatic kick(input logic [31:0] p);
        @(negedge clk);
        start = 1'b1;
        start_ptr = p;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_chain(input logic [31:0] p, input bit exp_err, input string req);
        bit gd = 0;
        bit ge = 0;
        kick(p);
        if (p[2:0] == 3'b000)
            check(rd_req_valid && rd_req_addr == p, "R2", "first fetch",
                  {31'd0, rd_req_valid, rd_req_addr}, {32'd1, p});
        else
            check(err && !rd_req_valid, "R9", "misaligned start err/noread",
                  {62'd0, err, rd_req_valid}, 64'd2);
        for (int i = 0; i < 3000; i++) begin
            if (done) gd = 1;
            if (err) ge = 1;
            if (gd || ge) break;
            @(negedge clk);
        end
        check(ge == exp_err && gd == !exp_err, req, "outcome done/err",
              {62'd0, gd, ge}, {62'd0, !exp_err, exp_err});
        check(exp_q.size() == 0, req, "all transfers seen", 64'(exp_q.size()), 64'd0);
        @(negedge clk);
        check(!busy, req, "idle after chain", {63'd0, busy}, 64'd0);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check({busy, rd_req_valid, xfer_valid, done, err} == 5'b0, "R1", "outputs in reset",
              {59'd0, busy, rd_req_valid, xfer_valid, done, err}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check({busy, rd_req_valid, xfer_valid, done, err} == 5'b0, "R1", "outputs after reset",
              {59'd0, busy, rd_req_valid, xfer_valid, done, err}, 64'd0);

        // R6: single last entry, misaligned next ignored, junk high bits of byte 9
        put(32'h0000_1000, 32'h1234_5678, 32'd1, 8'hB0, 8'hF5, 32'h0000_0003, 1);
        run_chain(32'h0000_1000, 0, "R6");

        // R5: three-entry chain, varied flags, full-range length (R3)
        put(32'h0000_2000, 32'hDEAD_BEE8, 32'hFFFF_FFFF, 8'h20, 8'h03, 32'h0000_2400, 1);
        put(32'h0000_2400, 32'h0000_0040, 32'd16, 8'h10, 8'h0C, 32'h0000_2100, 1);
        put(32'h0000_2100, 32'h8000_0000, 32'd2, 8'h80, 8'h0A, 32'h0000_0000, 1);
        run_chain(32'h0000_2000, 0, "R5");

        // R7: misaligned buffer address on second entry
        put(32'h0000_3000, 32'h0000_0100, 32'd4, 8'h00, 8'h01, 32'h0000_3010, 1);
        put(32'h0000_3010, 32'h0000_0104, 32'd4, 8'h80, 8'h01, 32'h0000_0000, 0);
        run_chain(32'h0000_3000, 1, "R7");

        // R7: misaligned next pointer on a non-last entry
        put(32'h0000_3100, 32'h0000_0200, 32'd4, 8'h00, 8'h01, 32'h0000_3114, 0);
        run_chain(32'h0000_3100, 1, "R7");

        // R8: zero length
        put(32'h0000_3200, 32'h0000_0300, 32'd0, 8'h80, 8'h01, 32'h0000_0000, 0);
        run_chain(32'h0000_3200, 1, "R8");

        // R9: misaligned start pointer
        run_chain(32'h0000_1004, 1, "R9");

        // R11 and R12: stall the sink, hold check, start while busy
        put(32'h0000_4000, 32'h0000_5000, 32'd8, 8'hB0, 8'h07, 32'h0000_0000, 1);
        sink_hold = 1'b1;
        kick(32'h0000_4000);
        for (int i = 0; i < 50 && !xfer_valid; i++) @(negedge clk);
        begin
            logic [31:0] a0;
            a0 = xfer_addr;
            start = 1'b1;
            start_ptr = 32'h0000_1000;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            check(xfer_valid && xfer_addr == a0, "R11", "command held in stall",
                  {31'd0, xfer_valid, xfer_addr}, {32'd1, a0});
        end
        sink_hold = 1'b0;
        begin
            bit gd = 0;
            for (int i = 0; i < 50; i++) begin
                if (done) begin gd = 1; break; end
                @(negedge clk);
            end
            check(gd && exp_q.size() == 0, "R12", "busy start ignored, chain finished",
                  {31'd0, gd, 32'(exp_q.size())}, {32'd1, 32'd0});
        end
        repeat (2) @(negedge clk);

        // R10: abort while a transfer is stalled
        put(32'h0000_4100, 32'h0000_6000, 32'd8, 8'h80, 8'h02, 32'h0000_0000, 0);
        sink_hold = 1'b1;
        kick(32'h0000_4100);
        for (int i = 0; i < 50 && !xfer_valid; i++) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        check(!busy && !xfer_valid && !rd_req_valid, "R10", "idle after abort",
              {61'd0, busy, xfer_valid, rd_req_valid}, 64'd0);
        sink_hold = 1'b0;
        begin
            bit gd = 0;
            for (int i = 0; i < 20; i++) begin
                if (done || xfer_valid) gd = 1;
                @(negedge clk);
            end
            check(!gd, "R10", "no done after abort", {63'd0, gd}, 64'd0);
        end

        // R2: a chain still works after abort
        put(32'h0000_4200, 32'h0000_7000, 32'd3, 8'hA0, 8'h09, 32'h0000_0001, 1);
        run_chain(32'h0000_4200, 0, "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule